// File: doc/BRIEF.md
# Tri-Level Pulse Qualifier

This block sits behind a comparator front end that watches one control line with three levels. Every clock it receives a two-bit code saying whether the line is low, mid, high or above the program threshold. It turns brief excursions away from mid into clean single-cycle strobes. A low excursion means count up and a high excursion means count down. A sustained over-threshold excursion is reported as a program request. All pulse widths are measured in ticks of a clock-enable input, which is normally one microsecond. Every time limit is a module parameter given in ticks.

Before the state machine sees the code, the code passes through a flop synchronizer and a stability filter. The machine then requires each excursion to last long enough and to return to mid. Count events are kept apart by a minimum spacing. Events are suppressed while the enable input is low, and for a start delay after the enable rises. An excursion that reaches program level never produces a count.

Top module: `tri_level_qualifier`

## Requirements
- R1: Level codes are 2'b00 low, 2'b01 mid, 2'b10 high, 2'b11 program. A qualified excursion from mid to low and back to mid gives exactly one `up_evt` pulse.
- R2: A qualified excursion from mid to high and back to mid gives exactly one `down_evt` pulse.
- R3: A count strobe is issued only after the filtered level has returned to mid. No strobe is issued while the line is still away from mid.
- R4: A filtered excursion lasting REJECT_TICKS ticks or fewer is discarded. One lasting REJECT_TICKS+1 ticks or more counts.
- R5: The code passes through SYNC_STAGES flops. A new level is accepted only after it has been steady for STABLE_TICKS ticks, so a one-clock glitch has no effect.
- R6: After a count strobe, an excursion that begins within GAP_TICKS ticks is ignored entirely. A later excursion counts normally.
- R7: Program level held for more than PROG_TICKS ticks gives one `prog_evt`, no matter how much longer it is held. A shorter hold gives nothing.
- R8: An excursion that reaches program level never yields `up_evt` or `down_evt`, even if it passes through high on the way in or out.
- R9: After `enable` rises, any excursion that starts within START_TICKS ticks is ignored.
- R10: While `enable` is low no strobe is issued. Dropping `enable` in the middle of an excursion cancels that excursion.
- R11: A direct swing between low and high with no return to mid between them is discarded.
- R12: At most one strobe is high in any cycle, and each strobe lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timing clock enable, one pulse per time unit |
| enable | input | 1 | Gates all events; rising edge starts the start delay |
| level_code | input | 2 | Comparator code of the control line (R1 encoding) |
| up_evt | output | 1 | One-cycle count-up strobe |
| down_evt | output | 1 | One-cycle count-down strobe |
| prog_evt | output | 1 | One-cycle program-request strobe |

## Verification
Some properties are checked on every cycle by assertions. The strobes are mutually exclusive and last one cycle. Strobes stop one cycle after `enable` falls. A count strobe follows a filtered level sequence of away-then-mid, and a program strobe follows program level. The filtered level commits only to a value that the synchronizer is currently presenting.

Other behaviour depends on how long a level is held, so only the bench scenarios can show it. This covers the width limit at exactly REJECT_TICKS versus REJECT_TICKS+1, glitch filtering, the spacing window and the start delay. It also covers program detection through high, and cancellation when enable drops.

// File: rtl/tlq_pkg.sv
package tlq_pkg;

   typedef enum logic [1:0] {
      LV_LOW  = 2'b00,
      LV_MID  = 2'b01,
      LV_HIGH = 2'b10,
      LV_PROG = 2'b11
   } lvl_e;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_START,
      ST_WAIT,
      ST_IDLE,
      ST_EXC,
      ST_GAP,
      ST_PROG,
      ST_PDONE
   } st_e;

endpackage

// File: rtl/tlq_sync.sv
module tlq_sync
   import tlq_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int STABLE_TICKS = 2
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic [1:0] lvl_in,
   output lvl_e       lvl_q
);

   localparam int SH_W = 2 * SYNC_STAGES;
   localparam int SW   = (STABLE_TICKS < 1) ? 1 : $clog2(STABLE_TICKS + 1);

   initial begin
      assert (SYNC_STAGES >= 1) else $error("tlq_sync: SYNC_STAGES must be at least 1");
      assert (STABLE_TICKS >= 0) else $error("tlq_sync: STABLE_TICKS must not be negative");
   end

   logic [SH_W-1:0] sh;
   lvl_e            raw;

   generate
      if (SYNC_STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= 2'b01;
            else        sh <= lvl_in;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= {SYNC_STAGES{2'b01}};
            else        sh <= {sh[SH_W-3:0], lvl_in};
         end
      end
   endgenerate

   assign raw = lvl_e'(sh[SH_W-1 -: 2]);

   generate
      if (STABLE_TICKS == 0) begin : g_bypass
         assign lvl_q = raw;
      end else begin : g_filter
         lvl_e          cand;
         logic [SW-1:0] scnt;
         lvl_e          lvl_r;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cand  <= LV_MID;
               scnt  <= '0;
               lvl_r <= LV_MID;
            end else if (raw != cand) begin
               cand <= raw;
               scnt <= '0;
            end else if (tick && scnt != SW'(STABLE_TICKS)) begin
               scnt <= scnt + 1'b1;
               if (scnt == SW'(STABLE_TICKS - 1)) lvl_r <= cand;
            end
         end

         assign lvl_q = lvl_r;

         // R5: a committed level is one the synchronizer was presenting
         p_commit_matches_raw_r5 : assert property (@(posedge clk) disable iff (!rst_n)
            (lvl_r != $past(lvl_r)) |-> ($past(raw) == lvl_r));
      end
   endgenerate

endmodule

// File: rtl/tlq_ticker.sv
module tlq_ticker #(
   parameter int W = 8
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         clr,
   output logic [W-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (clr)                cnt <= '0;
      else if (tick && !(&cnt))    cnt <= cnt + 1'b1;
   end

   // R4: the width timer saturates instead of wrapping
   p_timer_saturates_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      ((&cnt) && !clr) |=> (&cnt));

endmodule

// File: rtl/tri_level_qualifier.sv
module tri_level_qualifier
   import tlq_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int STABLE_TICKS = 2,
   parameter int START_TICKS  = 50,
   parameter int REJECT_TICKS = 20,
   parameter int GAP_TICKS    = 10,
   parameter int PROG_TICKS   = 200
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       enable,
   input  logic [1:0] level_code,
   output logic       up_evt,
   output logic       down_evt,
   output logic       prog_evt
);

   localparam int MAX_AB = (START_TICKS > REJECT_TICKS) ? START_TICKS : REJECT_TICKS;
   localparam int MAX_CD = (GAP_TICKS > PROG_TICKS) ? GAP_TICKS : PROG_TICKS;
   localparam int MAX_T  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
   localparam int CNT_W  = $clog2(MAX_T + 2);

   initial begin
      assert (REJECT_TICKS >= 1) else $error("tri_level_qualifier: REJECT_TICKS must be at least 1");
      assert (PROG_TICKS >= 1)   else $error("tri_level_qualifier: PROG_TICKS must be at least 1");
      assert (GAP_TICKS >= 0)    else $error("tri_level_qualifier: GAP_TICKS must not be negative");
      assert (START_TICKS >= 0)  else $error("tri_level_qualifier: START_TICKS must not be negative");
   end

   lvl_e             lvl;
   st_e              st, st_nx;
   logic             dir_low;
   logic [CNT_W-1:0] cnt;
   logic             fire_up, fire_dn, fire_pg;
   logic             clr;

   tlq_sync #(
      .SYNC_STAGES  (SYNC_STAGES),
      .STABLE_TICKS (STABLE_TICKS)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .lvl_in (level_code),
      .lvl_q  (lvl)
   );

   tlq_ticker #(.W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .clr   (clr),
      .cnt   (cnt)
   );

   always_comb begin
      st_nx   = st;
      fire_up = 1'b0;
      fire_dn = 1'b0;
      fire_pg = 1'b0;
      unique case (st)
         ST_OFF:   st_nx = ST_START;
         ST_START: if (cnt >= CNT_W'(START_TICKS)) st_nx = ST_WAIT;
         ST_WAIT:  if (lvl == LV_MID) st_nx = ST_IDLE;
         ST_IDLE: begin
            if (lvl == LV_LOW || lvl == LV_HIGH) st_nx = ST_EXC;
            else if (lvl == LV_PROG)             st_nx = ST_PROG;
         end
         ST_EXC: begin
            if (lvl == LV_PROG) begin
               st_nx = ST_PROG;
            end else if (lvl == LV_MID) begin
               if (cnt >= CNT_W'(REJECT_TICKS)) begin
                  fire_up = dir_low;
                  fire_dn = !dir_low;
                  st_nx   = ST_GAP;
               end else begin
                  st_nx = ST_IDLE;
               end
            end else if (lvl != (dir_low ? LV_LOW : LV_HIGH)) begin
               st_nx = ST_WAIT;
            end
         end
         ST_GAP: begin
            if (lvl != LV_MID)                  st_nx = ST_WAIT;
            else if (cnt >= CNT_W'(GAP_TICKS))  st_nx = ST_IDLE;
         end
         ST_PROG: begin
            if (lvl != LV_PROG) begin
               st_nx = ST_WAIT;
            end else if (tick && cnt >= CNT_W'(PROG_TICKS - 1)) begin
               fire_pg = 1'b1;
               st_nx   = ST_PDONE;
            end
         end
         ST_PDONE: if (lvl != LV_PROG) st_nx = ST_WAIT;
         default:  st_nx = ST_OFF;
      endcase
      if (!enable) begin
         st_nx   = ST_OFF;
         fire_up = 1'b0;
         fire_dn = 1'b0;
         fire_pg = 1'b0;
      end
   end

   assign clr = (st_nx != st);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_OFF;
         dir_low  <= 1'b0;
         up_evt   <= 1'b0;
         down_evt <= 1'b0;
         prog_evt <= 1'b0;
      end else begin
         st       <= st_nx;
         up_evt   <= fire_up;
         down_evt <= fire_dn;
         prog_evt <= fire_pg;
         if (st == ST_IDLE && (lvl == LV_LOW || lvl == LV_HIGH))
            dir_low <= (lvl == LV_LOW);
      end
   end

   // R12: strobes are exclusive and one cycle long
   p_one_strobe_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({up_evt, down_evt, prog_evt}));
   p_single_cycle_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      (up_evt || down_evt) |=> !(up_evt || down_evt));

   // R10: enable low silences the outputs on the next cycle
   p_quiet_when_off_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !(up_evt || down_evt || prog_evt));

   // R3: count strobes follow an away-then-mid level sequence
   p_up_trailing_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      up_evt |-> ($past(lvl) == LV_MID && $past(lvl, 2) == LV_LOW));
   p_down_trailing_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      down_evt |-> ($past(lvl) == LV_MID && $past(lvl, 2) == LV_HIGH));

   // R7: a program strobe is issued only while the line sits at program level
   p_prog_level_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      prog_evt |-> ($past(lvl) == LV_PROG));

endmodule

// File: tb/sim_tri_level_qualifier.sv
module sim_tri_level_qualifier;

   localparam int STABLE = 2;
   localparam int START  = 20;
   localparam int REJECT = 6;
   localparam int GAP    = 4;
   localparam int PROG   = 12;

   localparam logic [1:0] L = 2'b00;
   localparam logic [1:0] M = 2'b01;
   localparam logic [1:0] H = 2'b10;
   localparam logic [1:0] P = 2'b11;

   typedef struct packed {
      logic [1:0] a;  logic [7:0] na;
      logic [1:0] b;  logic [7:0] nb;
      logic [1:0] c;  logic [7:0] nc;
      logic [1:0] eu; logic [1:0] ed; logic [1:0] ep;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VEC [NV] = '{
      '{L, 8'd15, M, 8'd0,  M, 8'd0,  2'd1, 2'd0, 2'd0, 4'd1},   // R1 up
      '{H, 8'd15, M, 8'd0,  M, 8'd0,  2'd0, 2'd1, 2'd0, 4'd2},   // R2 down
      '{L, 8'd1,  M, 8'd0,  M, 8'd0,  2'd0, 2'd0, 2'd0, 4'd5},   // R5 glitch
      '{H, 8'd3,  M, 8'd0,  M, 8'd0,  2'd0, 2'd0, 2'd0, 4'd4},   // R4 short
      '{L, 8'd7,  M, 8'd0,  M, 8'd0,  2'd1, 2'd0, 2'd0, 4'd4},   // R4 REJECT+1
      '{L, 8'd6,  M, 8'd0,  M, 8'd0,  2'd0, 2'd0, 2'd0, 4'd4},   // R4 REJECT
      '{L, 8'd15, H, 8'd15, M, 8'd0,  2'd0, 2'd0, 2'd0, 4'd11},  // R11 swing
      '{L, 8'd15, M, 8'd3,  L, 8'd15, 2'd1, 2'd0, 2'd0, 4'd6},   // R6 in gap
      '{L, 8'd15, M, 8'd20, H, 8'd15, 2'd1, 2'd1, 2'd0, 4'd6},   // R6 after gap
      '{P, 8'd20, M, 8'd0,  M, 8'd0,  2'd0, 2'd0, 2'd1, 4'd7},   // R7 long
      '{P, 8'd8,  M, 8'd0,  M, 8'd0,  2'd0, 2'd0, 2'd0, 4'd7},   // R7 short
      '{H, 8'd10, P, 8'd20, H, 8'd10, 2'd0, 2'd0, 2'd1, 4'd8},   // R8 via high
      '{P, 8'd60, M, 8'd0,  M, 8'd0,  2'd0, 2'd0, 2'd1, 4'd7}    // R7 one only
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b1;
   logic       enable = 1'b0;
   logic [1:0] level_code = M;
   logic       up_evt, down_evt, prog_evt;

   int n_up = 0, n_dn = 0, n_pg = 0;
   int errors = 0, checks = 0;

   always #5 clk = ~clk;

   tri_level_qualifier #(
      .SYNC_STAGES  (2),
      .STABLE_TICKS (STABLE),
      .START_TICKS  (START),
      .REJECT_TICKS (REJECT),
      .GAP_TICKS    (GAP),
      .PROG_TICKS   (PROG)
   ) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .enable     (enable),
      .level_code (level_code),
      .up_evt     (up_evt),
      .down_evt   (down_evt),
      .prog_evt   (prog_evt)
   );

   always @(negedge clk) begin
      if (up_evt)   n_up++;
      if (down_evt) n_dn++;
      if (prog_evt) n_pg++;
   end

   task automatic chk(input int act, input int exp, input string tag);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic hold(input logic [1:0] lv, input int n);
      if (n > 0) begin
         level_code = lv;
         repeat (n) @(negedge clk);
      end
   endtask

   task automatic zero_counts();
      n_up = 0; n_dn = 0; n_pg = 0;
   endtask

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
      $finish;
   end

   initial begin
      // reset state
      repeat (3) @(negedge clk);
      chk(int'({up_evt, down_evt, prog_evt}), 0, "R12 reset strobes");
      rst_n = 1'b1;
      enable = 1'b1;
      repeat (2) @(negedge clk);
      chk(int'({up_evt, down_evt, prog_evt}), 0, "R12 after reset");
      hold(M, 40);

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         string tag;
         v = VEC[i];
         zero_counts();
         hold(M, 10);
         hold(v.a, int'(v.na));
         hold(v.b, int'(v.nb));
         hold(v.c, int'(v.nc));
         hold(M, 30);
         tag = $sformatf("R%0d vec%0d", v.req, i);
         chk(n_up, int'(v.eu), {tag, " up"});
         chk(n_dn, int'(v.ed), {tag, " down"});
         chk(n_pg, int'(v.ep), {tag, " prog"});
      end

      // R3: no strobe while still low; strobe after return to mid
      zero_counts();
      hold(L, 40);
      chk(n_up, 0, "R3 before return");
      hold(M, 30);
      chk(n_up, 1, "R3 after return");

      // R10: enable low blocks all events
      enable = 1'b0;
      zero_counts();
      hold(L, 15); hold(M, 30);
      hold(H, 15); hold(M, 30);
      hold(P, 20); hold(M, 30);
      chk(n_up + n_dn + n_pg, 0, "R10 disabled");

      // R9: excursion inside start delay ignored
      enable = 1'b1;
      zero_counts();
      hold(M, 2);
      hold(L, 30);
      hold(M, 30);
      chk(n_up, 0, "R9 inside start delay");
      hold(H, 15); hold(M, 30);
      chk(n_dn, 1, "R9 after start delay");

      // R10: dropping enable mid-excursion cancels it
      zero_counts();
      hold(L, 10);
      enable = 1'b0;
      hold(L, 5);
      hold(M, 30);
      chk(n_up, 0, "R10 cancelled");
      enable = 1'b1;
      hold(M, 40);
      hold(L, 15); hold(M, 30);
      chk(n_up, 1, "R1 after re-enable");

      summary();
      $finish;
   end

endmodule